// File: doc/BRIEF.md
# Multi-Light Pulse-Width Frame Transmitter

This block sends one frame of light-coded data over three LED on/off enables, all timed from one clock. Each bit is a single pulse per bit period. A zero is a short pulse, high for a quarter of the period. A one is a long pulse, high for three quarters of the period. In both cases the high part comes first.

A frame has four parts, sent in this order:
- A run of ones, sent on all lights at the same time.
- A three-byte header, also sent on all lights.
- The payload bits, interleaved across the lights.
- A guard interval with every light steadily on.

The header carries a fixed share-count byte, a payload-size byte and an epoch byte. In the payload part the lights take turns, one bit each, in ascending order. While one light sends its bit, the other two stay dark for the whole bit period. Each light works through its own six-byte buffer from the most significant bit down.

A frame is launched by a one-cycle start strobe. The header fields and all payload buffers are captured at that moment. The busy output covers the whole frame, including the guard. The control state machine has five states:
- IDLE: waits for the start strobe (transition *launch*).
- SYNC: sends the ones run (transition *sync_done*).
- HDR: sends the header (transition *hdr_done*).
- DATA: sends the interleaved payload (transition *data_done*).
- HOLD: keeps every light on for the guard time (transition *hold_done*, back to IDLE).

Top module: `lightcast_tx`

## Requirements
- R1: During and after reset, until the first accepted start, every light output and busy_o are low.
- R2: Each bit period lasts BIT_TICKS cycles. A 0 bit is high for the first BIT_TICKS/4 cycles and low for the rest. A 1 bit is high for the first 3*BIT_TICKS/4 cycles and low for the rest.
- R3: A start_i sampled high in IDLE is accepted. In the next cycle the first tick of the ones run begins. The ones run is SYNC_BITS one-bits, driven identically on all lights.
- R4: After the ones run, 24 header bits follow on all lights. The order is the byte 8'h02, then size_i, then epoch_i, each byte MSB first.
- R5: In the payload part, bit slots rotate across light_o[0], light_o[1], light_o[2], light_o[0], and so on. In each slot only the active light may be high, and the others stay low for the whole slot.
- R6: Light k transmits payload_i bits [48k+47 : 48k]. Bit 48k+47 goes first and bit 48k goes last.
- R7: After the final payload slot, all lights are high for exactly GUARD_TICKS cycles. Then all lights go low and the block returns to IDLE.
- R8: busy_o is high from the cycle after an accepted start until the end of the guard interval, and low otherwise.
- R9: A start_i that arrives while busy_o is high, including during the guard, has no effect on the frame in flight. It also does not launch a new frame afterwards.
- R10: Changes to size_i, epoch_i and payload_i after the start is accepted do not alter the frame being sent.
- R11: A start given in the first IDLE cycle after a guard interval is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame launch strobe |
| size_i | input | 8 | Payload-size header byte |
| epoch_i | input | 8 | Epoch header byte |
| payload_i | input | NUM_LIGHTS*PAY_BYTES*8 | Payload buffers; light k in slice k |
| light_o | output | NUM_LIGHTS | LED enables |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The output tick for frame bit b, tick t, is due combinationally from the registered state. It appears b*BIT_TICKS + t cycles after the first cycle that follows the edge that captured start_i. The bench drives start at a falling edge and waits one rising edge. It then samples every tick of every bit at falling edges, so each comparison sits mid-cycle, one register stage after the counter that moved. The guard is checked for exactly GUARD_TICKS samples after the last payload tick. Return to IDLE is checked on the sample after that, and the next frame's strobe is placed in that same cycle.

// File: rtl/lc_pkg.sv
package lc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HDR,
        ST_DATA,
        ST_HOLD
    } lc_state_t;

    localparam int HDR_BITS = 24;
    localparam logic [7:0] SHARE_COUNT = 8'h02;
endpackage

// File: rtl/lc_bit_timer.sv
module lc_bit_timer #(
    parameter int BIT_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic bit_i,
    output logic level_o,
    output logic last_o
);
    localparam int TW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam int HI_ZERO = BIT_TICKS / 4;
    localparam int HI_ONE = (3 * BIT_TICKS) / 4;

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run_i) begin
            tick_q <= '0;
        end else if (tick_q == TW'(BIT_TICKS - 1)) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_comb begin
        last_o  = run_i && (tick_q == TW'(BIT_TICKS - 1));
        level_o = run_i && (tick_q < (bit_i ? TW'(HI_ONE) : TW'(HI_ZERO)));
    end
endmodule

// File: rtl/lc_frame_seq.sv
module lc_frame_seq
    import lc_pkg::*;
#(
    parameter int NUM_LIGHTS  = 3,
    parameter int PAY_BYTES   = 6,
    parameter int SYNC_BITS   = 16,
    parameter int GUARD_TICKS = 4000,
    localparam int PBITS = PAY_BYTES * 8,
    localparam int PAY_W = NUM_LIGHTS * PBITS,
    localparam int SLOT_W = (NUM_LIGHTS > 1) ? $clog2(NUM_LIGHTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        size_i,
    input  logic [7:0]        epoch_i,
    input  logic [PAY_W-1:0]  payload_i,
    input  logic              last_tick_i,
    output logic              run_o,
    output logic              bit_o,
    output logic              bcast_o,
    output logic              hold_o,
    output logic              busy_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam int SEG_MAX = (SYNC_BITS > HDR_BITS) ? SYNC_BITS : HDR_BITS;
    localparam int SEG_W = $clog2(SEG_MAX);
    localparam int POS_W = (PBITS > 1) ? $clog2(PBITS) : 1;
    localparam int IDX_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;
    localparam int GW = $clog2(GUARD_TICKS + 1);

    lc_state_t state_q, state_d;
    logic [HDR_BITS-1:0] hdr_q;
    logic [PAY_W-1:0]    pay_q;
    logic [SEG_W-1:0]    seg_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [POS_W-1:0]    pos_q;
    logic [GW-1:0]       hold_q;
    logic [IDX_W-1:0]    pay_idx;
    logic [SEG_W-1:0]    hdr_idx;
    logic                sync_end, hdr_end, data_end, hold_end;

    always_comb begin
        sync_end = last_tick_i && (seg_q == SEG_W'(SYNC_BITS - 1));
        hdr_end  = last_tick_i && (seg_q == SEG_W'(HDR_BITS - 1));
        data_end = last_tick_i && (slot_q == SLOT_W'(NUM_LIGHTS - 1))
                   && (pos_q == POS_W'(PBITS - 1));
        hold_end = (hold_q == GW'(GUARD_TICKS - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, sync_done, hdr_done, data_done, hold_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_SYNC;
            ST_SYNC: if (sync_end) state_d = ST_HDR;
            ST_HDR:  if (hdr_end)  state_d = ST_DATA;
            ST_DATA: if (data_end) state_d = ST_HOLD;
            ST_HOLD: if (hold_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath counters and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            pay_q  <= '0;
            seg_q  <= '0;
            slot_q <= '0;
            pos_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    seg_q  <= '0;
                    slot_q <= '0;
                    pos_q  <= '0;
                    hold_q <= '0;
                    if (start_i) begin
                        hdr_q <= {SHARE_COUNT, size_i, epoch_i};
                        pay_q <= payload_i;
                    end
                end
                ST_SYNC: begin
                    if (sync_end) seg_q <= '0;
                    else if (last_tick_i) seg_q <= seg_q + 1'b1;
                end
                ST_HDR: begin
                    if (last_tick_i) seg_q <= seg_q + 1'b1;
                end
                ST_DATA: begin
                    if (last_tick_i) begin
                        if (slot_q == SLOT_W'(NUM_LIGHTS - 1)) begin
                            slot_q <= '0;
                            pos_q  <= pos_q + 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: hold_q <= hold_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        pay_idx = IDX_W'(slot_q) * IDX_W'(PBITS) + IDX_W'(PBITS - 1) - IDX_W'(pos_q);
        hdr_idx = SEG_W'(HDR_BITS - 1) - seg_q;
    end

    // outputs
    always_comb begin
        run_o   = 1'b0;
        bit_o   = 1'b0;
        bcast_o = 1'b0;
        hold_o  = 1'b0;
        busy_o  = 1'b1;
        slot_o  = slot_q;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_SYNC: begin
                run_o   = 1'b1;
                bit_o   = 1'b1;
                bcast_o = 1'b1;
            end
            ST_HDR: begin
                run_o   = 1'b1;
                bit_o   = hdr_q[hdr_idx];
                bcast_o = 1'b1;
            end
            ST_DATA: begin
                run_o = 1'b1;
                bit_o = pay_q[pay_idx];
            end
            ST_HOLD: hold_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lc_light_mux.sv
module lc_light_mux #(
    parameter int NUM_LIGHTS = 3,
    localparam int SLOT_W = (NUM_LIGHTS > 1) ? $clog2(NUM_LIGHTS) : 1
) (
    input  logic                  level_i,
    input  logic                  bcast_i,
    input  logic                  hold_i,
    input  logic [SLOT_W-1:0]     slot_i,
    output logic [NUM_LIGHTS-1:0] light_o
);
    for (genvar g = 0; g < NUM_LIGHTS; g++) begin : g_light
        always_comb begin
            light_o[g] = hold_i
                       | (level_i & (bcast_i | (slot_i == SLOT_W'(g))));
        end
    end
endmodule

// File: rtl/lightcast_tx.sv
module lightcast_tx #(
    parameter int NUM_LIGHTS  = 3,
    parameter int PAY_BYTES   = 6,
    parameter int SYNC_BITS   = 16,
    parameter int BIT_TICKS   = 2000,
    parameter int GUARD_TICKS = 4000,
    localparam int PAY_W = NUM_LIGHTS * PAY_BYTES * 8,
    localparam int SLOT_W = (NUM_LIGHTS > 1) ? $clog2(NUM_LIGHTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [7:0]            size_i,
    input  logic [7:0]            epoch_i,
    input  logic [PAY_W-1:0]      payload_i,
    output logic [NUM_LIGHTS-1:0] light_o,
    output logic                  busy_o
);
    logic              run, bit_val, bcast, hold, level, last_tick;
    logic [SLOT_W-1:0] slot;

    lc_frame_seq #(
        .NUM_LIGHTS (NUM_LIGHTS),
        .PAY_BYTES  (PAY_BYTES),
        .SYNC_BITS  (SYNC_BITS),
        .GUARD_TICKS(GUARD_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .size_i     (size_i),
        .epoch_i    (epoch_i),
        .payload_i  (payload_i),
        .last_tick_i(last_tick),
        .run_o      (run),
        .bit_o      (bit_val),
        .bcast_o    (bcast),
        .hold_o     (hold),
        .busy_o     (busy_o),
        .slot_o     (slot)
    );

    lc_bit_timer #(
        .BIT_TICKS(BIT_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .bit_i  (bit_val),
        .level_o(level),
        .last_o (last_tick)
    );

    lc_light_mux #(
        .NUM_LIGHTS(NUM_LIGHTS)
    ) u_mux (
        .level_i(level),
        .bcast_i(bcast),
        .hold_i (hold),
        .slot_i (slot),
        .light_o(light_o)
    );
endmodule

// File: rtl/lc_tx_chk.sv
module lc_tx_chk #(
    parameter int NUM_LIGHTS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [NUM_LIGHTS-1:0] light_o,
    input logic                  busy_o
);
    // R1
    idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (light_o == '0));

    // R5
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(light_o) <= 1) || (light_o == '1));

    // R8
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R3
    launch_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (light_o == '1));

    // R7
    guard_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(light_o) == '1));
endmodule

bind lightcast_tx lc_tx_chk #(.NUM_LIGHTS(NUM_LIGHTS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .light_o(light_o),
    .busy_o (busy_o)
);

// File: tb/lightcast_tx_test.sv
`timescale 1ns/1ps
module lightcast_tx_test;
    localparam int NL = 3;
    localparam int PB = 6;
    localparam int SB = 16;
    localparam int T  = 8;
    localparam int G  = 12;
    localparam int PBITS = PB * 8;
    localparam int PW = NL * PBITS;
    localparam int NBITS = SB + 24 + PW;
    localparam int HI0 = T / 4;
    localparam int HI1 = (3 * T) / 4;

    // {size, epoch, payload}
    localparam logic [PW+15:0] VEC [4] = '{
        {8'h06, 8'h01, {PW{1'b0}}},
        {8'h06, 8'hA5, {18{8'hFF}}},
        {8'h30, 8'h7E, {18{8'h5A}}},
        {8'hC3, 8'h0F, 48'h8000_0000_0001, 48'hFEDC_BA98_7654, 48'h0123_4567_89AB}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    size_i = '0;
    logic [7:0]    epoch_i = '0;
    logic [PW-1:0] payload_i = '0;
    logic [NL-1:0] light_o;
    logic          busy_o;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lightcast_tx #(
        .NUM_LIGHTS(NL), .PAY_BYTES(PB), .SYNC_BITS(SB),
        .BIT_TICKS(T), .GUARD_TICKS(G)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .epoch_i(epoch_i), .payload_i(payload_i),
        .light_o(light_o), .busy_o(busy_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // expected light pattern for one tick of frame bit b
    function automatic logic [NL-1:0] exp_lights(input int b, input int t,
            input logic [PW+15:0] v, output string req);
        logic [23:0] hdr;
        logic        bv;
        logic [NL-1:0] mask;
        int p;
        hdr = {8'h02, v[PW+15:PW+8], v[PW+7:PW]};
        if (b < SB) begin
            bv = 1'b1; mask = '1; req = "R3";
        end else if (b < SB + 24) begin
            bv = hdr[23 - (b - SB)]; mask = '1; req = "R4";
        end else begin
            p = b - SB - 24;
            bv = v[(p % NL) * PBITS + PBITS - 1 - (p / NL)];
            mask = NL'(1) << (p % NL);
            req = "R5/R6";
        end
        return (t < (bv ? HI1 : HI0)) ? mask : '0;
    endfunction

    // caller is at a negedge with the block idle
    task automatic send_frame(input logic [PW+15:0] v, input logic disturb, input string first_req);
        logic [NL-1:0] e;
        string req;
        int errs;
        logic [NL-1:0] act_l;
        logic [NL-1:0] exp_l;
        size_i = v[PW+15:PW+8];
        epoch_i = v[PW+7:PW];
        payload_i = v[PW-1:0];
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, first_req, int'(busy_o), 1);
        if (disturb) begin
            // R10: scramble inputs after capture
            size_i = ~size_i;
            epoch_i = ~epoch_i;
            payload_i = ~payload_i;
        end
        for (int b = 0; b < NBITS; b++) begin
            errs = 0;
            act_l = '0;
            exp_l = '0;
            for (int t = 0; t < T; t++) begin
                e = exp_lights(b, t, v, req);
                if (light_o !== e || busy_o !== 1'b1) begin
                    if (errs == 0) begin
                        act_l = light_o;
                        exp_l = e;
                    end
                    errs++;
                end
                // R9: strobe while busy in a header bit
                start_i = disturb && (b == 20) && (t == 3);
                @(negedge clk);
            end
            start_i = 1'b0;
            if (b == 0) req = "R2/R3";
            chk(errs == 0, disturb ? {req, "/R10"} : req, int'(act_l), int'(exp_l));
        end
        errs = 0;
        for (int g = 0; g < G; g++) begin
            if (light_o !== '1 || busy_o !== 1'b1) errs++;
            start_i = disturb && (g == 2);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(errs == 0, "R7 guard", errs, 0);
        chk(light_o === '0 && busy_o === 1'b0, "R7/R8 back to idle",
            int'({light_o, busy_o}), 0);
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(light_o === '0 && busy_o === 1'b0, "R1 in reset", int'({light_o, busy_o}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(light_o === '0 && busy_o === 1'b0, "R1 after reset", int'({light_o, busy_o}), 0);

        // table walk; frames are back to back
        for (int i = 0; i < 4; i++) begin
            send_frame(VEC[i], i == 2, (i == 0) ? "R8" : "R11");
        end

        // R9: the strobe given during the guard launched nothing
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && light_o === '0, "R9 no relaunch",
            int'({light_o, busy_o}), 0);

        // R1: reset in mid frame
        size_i = 8'h11;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(light_o === '0 && busy_o === 1'b0, "R1 mid-frame reset",
            int'({light_o, busy_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(light_o === '0 && busy_o === 1'b0, "R1 idle after reset",
            int'({light_o, busy_o}), 0);

        // after reset the block still launches
        send_frame(VEC[3], 1'b0, "R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule